// File: doc/BRIEF.md
# Message Buffer Interrupt Aggregator

This block gathers completion events from 64 message buffers and two controller status events (bus-off and error), latches each one in a sticky flag, and turns them into a fixed set of 20 interrupt lines. Buffers 0 to 15 each own a dedicated line. Buffers 16 to 31 share one grouped line, and buffers 32 to 63 share another. Bus-off and error each have their own line.

A buffer flag does not record whether the completion was a transmit or a receive. Software reads the flag words to find out which buffer fired and clears bits by writing ones. A per-buffer mask, and a separate enable for each status event, decide which flags reach the outputs.

Events arrive from the protocol engine as single-cycle pulses. A narrow register port with write and combinational read gives access to flags, masks, status and control.

Top module: `irq_agg`

## Requirements
- R1: After reset every flag, mask, status and control bit reads as zero and all 20 interrupt outputs are low.
- R2: A pulse on `bufDone[i]` sets flag i at the next clock edge. Flags 0–31 read at address 0 (bit i). Flags 32–63 read at address 1 (bit i-32).
- R3: Writing to address 0 or 1 clears every flag bit written with 1 and leaves every bit written with 0 unchanged.
- R4: When a completion pulse and a write-1 clear hit the same flag bit in the same cycle, the flag ends up set.
- R5: Mask bits for buffers 0–31 are read and written at address 2, and those for buffers 32–63 at address 3. `bufIrq[i]` (i < 16) is high in the cycle after the cycle in which flag i and mask i were both set.
- R6: `grpIrqMid` is high in the cycle after any buffer in 16–31 had both its flag and its mask set.
- R7: `grpIrqHigh` is high in the cycle after any buffer in 32–63 had both its flag and its mask set.
- R8: Address 4 holds the sticky status bits: bit 0 is bus-off and bit 1 is error. A pulse sets the bit, a write of 1 clears it, and a pulse wins over a clear in the same cycle.
- R9: Address 5 holds the enables: bit 0 enables bus-off and bit 1 enables error. `busOffIrq` and `errorIrq` are high in the cycle after the matching status bit and enable were both set.
- R10: Addresses 6 and 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register address for read and write |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| bufDone | input | 64 | Per-buffer completion pulses |
| busOffPulse | input | 1 | Bus-off event pulse |
| errorPulse | input | 1 | Error event pulse |
| bufIrq | output | 16 | Dedicated interrupt lines, buffers 0–15 |
| grpIrqMid | output | 1 | Grouped interrupt, buffers 16–31 |
| grpIrqHigh | output | 1 | Grouped interrupt, buffers 32–63 |
| busOffIrq | output | 1 | Bus-off interrupt |
| errorIrq | output | 1 | Error interrupt |

## Verification
The assertions assume that events may arrive in any combination and in any cycle, including the same cycle as a register write to the same bits. They assume nothing about pulse spacing beyond each pulse being one cycle long. The stimulus drives every event pulse and every write for exactly one cycle and returns the inputs to idle at the next falling edge. Random writes land on all eight addresses, with data wide enough to clear many flags at once. Directed steps force the pulse-against-clear collision and writes to the unused addresses.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  parameter int NUM_BUF   = 64;
  parameter int REG_W     = 32;
  parameter int DIRECT    = 16;
  parameter int MID_END   = 32;
  parameter int ADDR_W    = 3;
  localparam int NUM_WORDS = NUM_BUF / REG_W;
  localparam int ADDR_STAT = 2 * NUM_WORDS;
  localparam int ADDR_CTRL = 2 * NUM_WORDS + 1;

  typedef struct packed {
    logic [NUM_WORDS-1:0] wrFlag;
    logic [NUM_WORDS-1:0] wrMask;
    logic                 wrStatus;
    logic                 wrCtrl;
  } wrStrobes_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output wrStrobes_t        strb
);
  always_comb begin
    strb = '0;
    if (regWrEn) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (regAddr == ADDR_W'(w))             strb.wrFlag[w] = 1'b1;
        if (regAddr == ADDR_W'(NUM_WORDS + w)) strb.wrMask[w] = 1'b1;
      end
      if (regAddr == ADDR_W'(ADDR_STAT)) strb.wrStatus = 1'b1;
      if (regAddr == ADDR_W'(ADDR_CTRL)) strb.wrCtrl   = 1'b1;
    end
  end

  // R10: at most one register is written per cycle; unused addresses strobe nothing
  assert_onehot_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
  assert_unused_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr > ADDR_W'(ADDR_CTRL)) |-> (strb == '0));
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  wrStrobes_t         strb,
  input  logic [REG_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [REG_W-1:0]   rdData,
  input  logic [NUM_BUF-1:0] bufDone,
  input  logic               busOffPulse,
  input  logic               errorPulse,
  output logic [DIRECT-1:0]  bufIrq,
  output logic               grpIrqMid,
  output logic               grpIrqHigh,
  output logic               busOffIrq,
  output logic               errorIrq
);
  logic [NUM_BUF-1:0] flags;
  logic [NUM_BUF-1:0] masks;
  logic [NUM_BUF-1:0] armed;
  logic [1:0]         stat;
  logic [1:0]         ctrl;

  assign armed = flags & masks;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
      masks <= '0;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        flags[w*REG_W +: REG_W] <= (flags[w*REG_W +: REG_W]
                                    & ~(strb.wrFlag[w] ? wrData : '0))
                                   | bufDone[w*REG_W +: REG_W];
        if (strb.wrMask[w]) masks[w*REG_W +: REG_W] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stat <= '0;
      ctrl <= '0;
    end else begin
      stat <= (stat & ~(strb.wrStatus ? wrData[1:0] : 2'b00)) | {errorPulse, busOffPulse};
      if (strb.wrCtrl) ctrl <= wrData[1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufIrq     <= '0;
      grpIrqMid  <= 1'b0;
      grpIrqHigh <= 1'b0;
      busOffIrq  <= 1'b0;
      errorIrq   <= 1'b0;
    end else begin
      bufIrq     <= armed[DIRECT-1:0];
      grpIrqMid  <= |armed[MID_END-1:DIRECT];
      grpIrqHigh <= |armed[NUM_BUF-1:MID_END];
      busOffIrq  <= stat[0] & ctrl[0];
      errorIrq   <= stat[1] & ctrl[1];
    end
  end

  always_comb begin
    rdData = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (rdAddr == ADDR_W'(w))             rdData = flags[w*REG_W +: REG_W];
      if (rdAddr == ADDR_W'(NUM_WORDS + w)) rdData = masks[w*REG_W +: REG_W];
    end
    if (rdAddr == ADDR_W'(ADDR_STAT)) rdData = {{(REG_W-2){1'b0}}, stat};
    if (rdAddr == ADDR_W'(ADDR_CTRL)) rdData = {{(REG_W-2){1'b0}}, ctrl};
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_flagChecks
    // R2 and R4: every pulsed bit is set afterwards, whatever was written
    assert_pulse_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
      (bufDone[w*REG_W +: REG_W] != '0) |=>
        ((flags[w*REG_W +: REG_W] & $past(bufDone[w*REG_W +: REG_W]))
          == $past(bufDone[w*REG_W +: REG_W])));
    // R3: without a write no flag falls
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
      !strb.wrFlag[w] |=>
        ((flags[w*REG_W +: REG_W] & $past(flags[w*REG_W +: REG_W]))
          == $past(flags[w*REG_W +: REG_W])));
    // R3: written ones without a new pulse are clear afterwards
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
      strb.wrFlag[w] |=>
        ((flags[w*REG_W +: REG_W]
          & $past(wrData & ~bufDone[w*REG_W +: REG_W])) == '0));
  end

  assert_grp_mid_R6: assert property (@(posedge clk) disable iff (!rstN)
    grpIrqMid |-> $past(|(flags[MID_END-1:DIRECT] & masks[MID_END-1:DIRECT])));
  assert_grp_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    grpIrqHigh |-> $past(|(flags[NUM_BUF-1:MID_END] & masks[NUM_BUF-1:MID_END])));
  assert_busoff_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    busOffPulse |=> stat[0]);
  assert_error_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    errorPulse |=> stat[1]);
  assert_busoff_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOffIrq) |-> $past(stat[0] && ctrl[0]));
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   regAddr,
  input  logic         regWrEn,
  input  logic [31:0]  regWrData,
  output logic [31:0]  regRdData,
  input  logic [63:0]  bufDone,
  input  logic         busOffPulse,
  input  logic         errorPulse,
  output logic [15:0]  bufIrq,
  output logic         grpIrqMid,
  output logic         grpIrqHigh,
  output logic         busOffIrq,
  output logic         errorIrq
);
  wrStrobes_t strb;

  irq_agg_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  irq_agg_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (regWrData),
    .rdAddr      (regAddr),
    .rdData      (regRdData),
    .bufDone     (bufDone),
    .busOffPulse (busOffPulse),
    .errorPulse  (errorPulse),
    .bufIrq      (bufIrq),
    .grpIrqMid   (grpIrqMid),
    .grpIrqHigh  (grpIrqHigh),
    .busOffIrq   (busOffIrq),
    .errorIrq    (errorIrq)
  );
endmodule

// File: tb/test_irq_agg.sv
`timescale 1ns/1ps
module test_irq_agg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] bufDone = '0;
  logic        busOffPulse = 1'b0;
  logic        errorPulse = 1'b0;
  logic [15:0] bufIrq;
  logic        grpIrqMid, grpIrqHigh, busOffIrq, errorIrq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] mFlag = '0, mMask = '0;
  logic [1:0]  mStat = '0, mCtrl = '0;
  logic [15:0] eBufIrq = '0;
  logic        eMid = 0, eHigh = 0, eBo = 0, eEr = 0;

  always #5 clk = ~clk;

  irq_agg i_irq_agg (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .bufDone(bufDone),
    .busOffPulse(busOffPulse), .errorPulse(errorPulse), .bufIrq(bufIrq),
    .grpIrqMid(grpIrqMid), .grpIrqHigh(grpIrqHigh),
    .busOffIrq(busOffIrq), .errorIrq(errorIrq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expRead(input int a);
    case (a)
      0: return mFlag[31:0];
      1: return mFlag[63:32];
      2: return mMask[31:0];
      3: return mMask[63:32];
      4: return {30'd0, mStat};
      5: return {30'd0, mCtrl};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagFor(input int a);
    case (a)
      0, 1: return "R2 flag word";
      2, 3: return "R5 mask word";
      4: return "R8 status";
      5: return "R9 control";
      default: return "R10 unused address";
    endcase
  endfunction

  task automatic checkRegs();
    for (int a = 0; a < 8; a++) begin
      regAddr = a[2:0];
      #0.4;
      chk(regRdData == expRead(a), tagFor(a), {32'd0, regRdData}, {32'd0, expRead(a)});
    end
  endtask

  task automatic checkOuts();
    chk(bufIrq == eBufIrq, "R5 bufIrq", {48'd0, bufIrq}, {48'd0, eBufIrq});
    chk(grpIrqMid == eMid, "R6 grpIrqMid", {63'd0, grpIrqMid}, {63'd0, eMid});
    chk(grpIrqHigh == eHigh, "R7 grpIrqHigh", {63'd0, grpIrqHigh}, {63'd0, eHigh});
    chk(busOffIrq == eBo, "R9 busOffIrq", {63'd0, busOffIrq}, {63'd0, eBo});
    chk(errorIrq == eEr, "R9 errorIrq", {63'd0, errorIrq}, {63'd0, eEr});
  endtask

  task automatic modelEdge(input logic [63:0] dn, input logic bo, input logic er,
                           input logic we, input logic [2:0] a, input logic [31:0] d);
    logic [63:0] clr;
    eBufIrq = mFlag[15:0] & mMask[15:0];
    eMid    = |(mFlag[31:16] & mMask[31:16]);
    eHigh   = |(mFlag[63:32] & mMask[63:32]);
    eBo     = mStat[0] & mCtrl[0];
    eEr     = mStat[1] & mCtrl[1];
    clr = '0;
    if (we && a == 3'd0) clr[31:0] = d;
    if (we && a == 3'd1) clr[63:32] = d;
    mFlag = (mFlag & ~clr) | dn;
    if (we && a == 3'd2) mMask[31:0] = d;
    if (we && a == 3'd3) mMask[63:32] = d;
    if (we && a == 3'd4) mStat = mStat & ~d[1:0];
    mStat = mStat | {er, bo};
    if (we && a == 3'd5) mCtrl = d[1:0];
  endtask

  task automatic step(input logic [63:0] dn, input logic bo, input logic er,
                      input logic we, input logic [2:0] a, input logic [31:0] d);
    bufDone = dn; busOffPulse = bo; errorPulse = er;
    regWrEn = we; regAddr = a; regWrData = d;
    @(posedge clk);
    modelEdge(dn, bo, er, we, a, d);
    @(negedge clk);
    bufDone = '0; busOffPulse = 1'b0; errorPulse = 1'b0; regWrEn = 1'b0;
    checkOuts();
    checkRegs();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7311));
    repeat (3) @(negedge clk);
    // R1: reset state
    checkOuts();
    checkRegs();
    chk(bufIrq == 16'd0, "R1 outputs low in reset", {48'd0, bufIrq}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkRegs();
    chk({grpIrqMid, grpIrqHigh, busOffIrq, errorIrq} == 4'd0, "R1 outputs after reset",
        {60'd0, grpIrqMid, grpIrqHigh, busOffIrq, errorIrq}, 64'd0);

    // R5 latency: mask then flag buffer 3
    step(64'd0, 0, 0, 1, 3'd2, 32'hFFFF_FFFF);
    step(64'h8, 0, 0, 0, 3'd0, 32'd0);
    chk(bufIrq[3] == 1'b0, "R5 not before one cycle", {63'd0, bufIrq[3]}, 64'd0);
    step(64'd0, 0, 0, 0, 3'd0, 32'd0);
    chk(bufIrq[3] == 1'b1, "R5 bufIrq[3] raised", {63'd0, bufIrq[3]}, 64'd1);

    // R4: pulse on bit 5 with a clear of bit 5 in the same cycle
    step(64'h20, 0, 0, 1, 3'd0, 32'h20);
    regAddr = 3'd0; #0.4;
    chk(regRdData[5] == 1'b1, "R4 set wins over clear", {63'd0, regRdData[5]}, 64'd1);

    // R3: clear bit 3 only, bit 5 stays
    step(64'd0, 0, 0, 1, 3'd0, 32'h8);
    regAddr = 3'd0; #0.4;
    chk(regRdData[3] == 1'b0, "R3 write-1 clears", {63'd0, regRdData[3]}, 64'd0);
    chk(regRdData[5] == 1'b1, "R3 write-0 keeps", {63'd0, regRdData[5]}, 64'd1);

    // R8: bus-off pulse against a clear of the same bit
    step(64'd0, 1, 0, 1, 3'd4, 32'h1);
    regAddr = 3'd4; #0.4;
    chk(regRdData[0] == 1'b1, "R8 pulse wins over clear", {63'd0, regRdData[0]}, 64'd1);

    // R10: writes to unused addresses
    step(64'd0, 0, 0, 1, 3'd6, 32'hFFFF_FFFF);
    step(64'd0, 0, 0, 1, 3'd7, 32'hFFFF_FFFF);

    // Random mix (R2 R5 R6 R7 R8 R9 R10 checked through model)
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] dn;
      logic we;
      dn = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
           & {$urandom, $urandom} & {$urandom, $urandom};
      we = ($urandom % 3) == 0;
      step(dn, ($urandom % 16) == 0, ($urandom % 16) == 0, we,
           3'($urandom % 8), $urandom & $urandom);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule